// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Register Block

This block holds the slot control and slot status registers of a downstream or root port that has a hot-plug slot, and it decides when software must be told about a hot-plug event. Software writes the control register through a synchronous write port with byte enables. It clears event bits in the status register by writing ones to them. The slot side reports attention-button presses, external command completion, and insertion or removal of a card.

A two-state occupancy machine tracks the slot. In state `SLOT_EMPTY`, an accepted insertion takes the transition *insert* to `SLOT_FULL`. In state `SLOT_FULL`, an accepted removal takes the transition *remove* back to `SLOT_EMPTY`. Both transitions raise a presence-changed event. A request that arrives while the electromechanical interlock is engaged takes the *refuse* self-loop: the state holds and an error pulse is raised. A request that does not fit the current state takes the *ignore* self-loop.

Notification goes out on one of two paths, chosen by `msi_en`. With the message path enabled, the block emits a one-cycle request pulse. The message itself is formed elsewhere. With it disabled, the block drives a registered level interrupt.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, `slot_ctl` reads 0x03C0, with both indicator fields [7:6] and [9:8] at the "off" code 2'b11. In the same state, `slot_sts` reads 0x0000, `intx_out` is 0, `msi_req` is 0 and `hp_reject` is 0.
- R2: A control write (`cfg_wr`=1, `cfg_sel`=0) updates only the bytes whose `cfg_be` bit is 1. Only bits 0, 3, 4, 5 and 6..10 are stored (mask 0x07F9). All other control bits read 0. With no control write, `slot_ctl` holds its value.
- R3: Control bit 11 (interlock control) always reads 0. A control write that puts 1 into bit 11 inverts status bit 7 (interlock engaged).
- R4: A control write whose merged value differs from the stored value in any bit of mask 0x0FF9 sets command-completed (status bit 4). A write that changes none of those bits leaves the status bits unchanged. A pulse on `cmd_done` also sets bit 4.
- R5: Status event bits are attention pressed (0), presence changed (3) and command completed (4). Events only set these bits. A status write (`cfg_sel`=1) with byte 0 enabled clears each event bit that is written with 1. If an event and a clear reach the same bit in the same cycle, the event wins.
- R6: Status bit 6 shows presence. `hp_insert` in `SLOT_EMPTY` sets bit 6, and `hp_remove` in `SLOT_FULL` clears it. Each of these transitions sets bit 3. A request that does not fit the current state changes nothing.
- R7: While status bit 7 is 1, an `hp_insert` or `hp_remove` is refused. `hp_reject` is then 1 for one cycle, and neither presence nor bit 3 changes.
- R8: With `msi_en`=0, `intx_out` equals HPIE (control bit 5) AND the OR over bits {0,3,4} of (control AND status). The value seen after an edge is computed from the register values produced by that same edge.
- R9: With `msi_en`=1, `msi_req` is 1 for one cycle when an event bit goes from 0 to 1 while HPIE and that bit's enable (the same bit position in control) are both 1. An event whose status bit is already 1 requests nothing.
- R10: With `msi_en`=1, a control write whose result has HPIE=1 also requests an MSI when one of enables {0,3,4} goes from 0 to 1 in that write and the matching status bit was already 1.
- R11: `msi_req` is never 1 unless `msi_en` was 1 at the deciding edge, and `intx_out` is never 1 unless `msi_en` was 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 control, 1 status |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| slot_ctl | output | 16 | Control register read value |
| slot_sts | output | 16 | Status register read value |
| msi_en | input | 1 | Selects the message path (1) or the level interrupt (0) |
| attn_press | input | 1 | Attention button press event |
| cmd_done | input | 1 | External command completion event |
| hp_insert | input | 1 | Card insertion request |
| hp_remove | input | 1 | Card removal request |
| hp_reject | output | 1 | Insertion or removal refused because the interlock is engaged |
| intx_out | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it are sampled. This covers register contents, the presence and interlock bits, the refusal pulse, the level interrupt and the message request. The bench drives each stimulus at a falling edge and compares all five outputs at the next falling edge, one edge later. The expected values come from a requirement-level model that the bench advances once per cycle. An MSI request must therefore show up in exactly that one compare window and be gone in the next.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W = 16;
    localparam int BE_W  = REG_W / 8;

    localparam int B_ABP  = 0;
    localparam int B_PDC  = 3;
    localparam int B_CC   = 4;
    localparam int B_HPIE = 5;
    localparam int B_EIC  = 11;
    localparam int B_PDS  = 6;
    localparam int B_EIS  = 7;

    localparam logic [REG_W-1:0] EVT_MASK   = REG_W'((1 << B_ABP) | (1 << B_PDC) | (1 << B_CC));
    localparam logic [REG_W-1:0] CTL_STORE  = REG_W'(16'h07F9);
    localparam logic [REG_W-1:0] CTL_CMD    = REG_W'(16'h0FF9);
    localparam logic [REG_W-1:0] CTL_RESET  = REG_W'(16'h03C0);

    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } occ_state_e;
endpackage

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] be_mask,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] ctl_nxt,
    output logic             cmd_change,
    output logic             eic_hit,
    output logic [REG_W-1:0] en_rise
);
    logic [REG_W-1:0] merged;

    always_comb begin
        merged     = (ctl_q & ~be_mask) | (wdata & be_mask);
        ctl_nxt    = ctl_q;
        cmd_change = 1'b0;
        eic_hit    = 1'b0;
        en_rise    = '0;
        if (wr_ctl) begin
            ctl_nxt    = merged & CTL_STORE;
            cmd_change = |((merged ^ ctl_q) & CTL_CMD);
            eic_hit    = merged[B_EIC];
            en_rise    = ctl_nxt & ~ctl_q & EVT_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_nxt;
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_ctl) |-> $stable(ctl_q)); // R2
endmodule

// File: rtl/hp_slot_occupancy.sv
module hp_slot_occupancy
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_req,
    input  logic rem_req,
    input  logic locked,
    output logic present,
    output logic pdc_evt,
    output logic reject_q
);
    occ_state_e state_q, state_d;
    logic       reject_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SLOT_EMPTY;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reject_q <= reject_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        pdc_evt  = 1'b0;
        reject_d = 1'b0;
        if (locked && (ins_req || rem_req)) begin
            reject_d = 1'b1;
        end else begin
            unique case (state_q)
                SLOT_EMPTY: if (ins_req) begin
                    state_d = SLOT_FULL;
                    pdc_evt = 1'b1;
                end
                SLOT_FULL: if (rem_req) begin
                    state_d = SLOT_EMPTY;
                    pdc_evt = 1'b1;
                end
                default: state_d = SLOT_EMPTY;
            endcase
        end
    end

    assign present = (state_q == SLOT_FULL);

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reject_q |-> $stable(state_q)); // R7
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sw_clr,
    input  logic [REG_W-1:0] ev,
    input  logic             eic_toggle,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] sts_nxt,
    output logic [REG_W-1:0] new_set
);
    always_comb begin
        sts_nxt        = ((sts_q & ~sw_clr) | ev) & EVT_MASK;
        sts_nxt[B_EIS] = sts_q[B_EIS] ^ eic_toggle;
        new_set        = ev & ~sts_q & EVT_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_nxt;
    end

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts_q) & ~sts_q & ~$past(sw_clr) & EVT_MASK) == '0)); // R5
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msi_en,
    input  logic [REG_W-1:0] ctl_nxt,
    input  logic [REG_W-1:0] sts_q,
    input  logic [REG_W-1:0] sts_nxt,
    input  logic [REG_W-1:0] new_set,
    input  logic [REG_W-1:0] en_rise,
    output logic             intx_q,
    output logic             msi_q
);
    logic msi_d, intx_d;

    always_comb begin
        msi_d  = msi_en & ctl_nxt[B_HPIE] &
                 (|(((new_set & ctl_nxt) | (en_rise & sts_q)) & EVT_MASK));
        intx_d = ~msi_en & ctl_nxt[B_HPIE] & (|(ctl_nxt & sts_nxt & EVT_MASK));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_q  <= 1'b0;
            intx_q <= 1'b0;
        end else begin
            msi_q  <= msi_d;
            intx_q <= intx_d;
        end
    end

    AST_MSI_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_q |-> $past(msi_en)); // R11
    AST_INTX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        intx_q |-> !$past(msi_en)); // R11
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [BE_W-1:0]  cfg_be,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] slot_ctl,
    output logic [REG_W-1:0] slot_sts,
    input  logic             msi_en,
    input  logic             attn_press,
    input  logic             cmd_done,
    input  logic             hp_insert,
    input  logic             hp_remove,
    output logic             hp_reject,
    output logic             intx_out,
    output logic             msi_req
);
    logic [REG_W-1:0] be_mask, ctl_q, ctl_nxt, en_rise;
    logic [REG_W-1:0] sts_q, sts_nxt, new_set, sw_clr, ev;
    logic             cmd_change, eic_hit, present, pdc_evt;

    for (genvar b = 0; b < BE_W; b++) begin : g_be
        assign be_mask[b*8 +: 8] = {8{cfg_be[b]}};
    end

    hp_slot_ctl i_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (cfg_wr & ~cfg_sel),
        .be_mask    (be_mask),
        .wdata      (cfg_wdata),
        .ctl_q      (ctl_q),
        .ctl_nxt    (ctl_nxt),
        .cmd_change (cmd_change),
        .eic_hit    (eic_hit),
        .en_rise    (en_rise)
    );

    hp_slot_occupancy i_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_req  (hp_insert),
        .rem_req  (hp_remove),
        .locked   (sts_q[B_EIS]),
        .present  (present),
        .pdc_evt  (pdc_evt),
        .reject_q (hp_reject)
    );

    always_comb begin
        sw_clr = (cfg_wr && cfg_sel) ? (cfg_wdata & be_mask & EVT_MASK) : '0;
        ev          = '0;
        ev[B_ABP]   = attn_press;
        ev[B_PDC]   = pdc_evt;
        ev[B_CC]    = cmd_done | cmd_change;
    end

    hp_slot_status i_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_clr     (sw_clr),
        .ev         (ev),
        .eic_toggle (eic_hit),
        .sts_q      (sts_q),
        .sts_nxt    (sts_nxt),
        .new_set    (new_set)
    );

    hp_slot_notify i_ntf (
        .clk     (clk),
        .rst_n   (rst_n),
        .msi_en  (msi_en),
        .ctl_nxt (ctl_nxt),
        .sts_q   (sts_q),
        .sts_nxt (sts_nxt),
        .new_set (new_set),
        .en_rise (en_rise),
        .intx_q  (intx_out),
        .msi_q   (msi_req)
    );

    always_comb begin
        slot_ctl        = ctl_q;
        slot_sts        = sts_q;
        slot_sts[B_PDS] = present;
    end

    AST_CC_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_change |=> slot_sts[B_CC]); // R4
    AST_EIC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eic_hit |=> (slot_sts[B_EIS] != $past(slot_sts[B_EIS]))); // R3
    AST_EIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> !slot_ctl[B_EIC]); // R3
endmodule

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] slot_ctl, slot_sts;
    logic        msi_en = 1'b0, attn_press = 1'b0, cmd_done = 1'b0;
    logic        hp_insert = 1'b0, hp_remove = 1'b0;
    logic        hp_reject, intx_out, msi_req;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_ctl, m_sts;
    bit          m_full;
    bit          m_men;

    always #5 clk = ~clk;

    hp_slot_ctrl i_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .slot_ctl(slot_ctl),
        .slot_sts(slot_sts), .msi_en(msi_en), .attn_press(attn_press),
        .cmd_done(cmd_done), .hp_insert(hp_insert), .hp_remove(hp_remove),
        .hp_reject(hp_reject), .intx_out(intx_out), .msi_req(msi_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // One stimulus cycle: drive at falling edge, compare at next falling edge.
    task automatic cycle(input bit wr, input bit sel, input logic [1:0] be,
                         input logic [15:0] wd, input bit attn, input bit cmdd,
                         input bit ins, input bit rem);
        logic [15:0] bm, merged, nctl, clr, ev, rise, nsts, nset;
        bit chg, eic, rej, pdc, nfull, e_msi, e_intx;
        cfg_wr = wr; cfg_sel = sel; cfg_be = be; cfg_wdata = wd;
        attn_press = attn; cmd_done = cmdd; hp_insert = ins; hp_remove = rem;
        msi_en = m_men;
        bm = {{8{be[1]}}, {8{be[0]}}};
        nctl = m_ctl; chg = 0; eic = 0; rise = '0;
        if (wr && !sel) begin
            merged = (m_ctl & ~bm) | (wd & bm);
            chg    = |((merged ^ m_ctl) & 16'h0FF9);
            eic    = merged[11];
            nctl   = merged & 16'h07F9;
            rise   = nctl & ~m_ctl & 16'h0019;
        end
        clr = (wr && sel) ? (wd & bm & 16'h0019) : 16'h0000;
        rej = 0; pdc = 0; nfull = m_full;
        if ((ins || rem) && m_sts[7]) rej = 1;
        else if (ins && !m_full) begin nfull = 1; pdc = 1; end
        else if (rem && m_full)  begin nfull = 0; pdc = 1; end
        ev = '0; ev[0] = attn; ev[3] = pdc; ev[4] = cmdd | chg;
        nset = ev & ~m_sts & 16'h0019;
        nsts = ((m_sts & ~clr) | ev) & 16'h0019;
        nsts[6] = nfull; nsts[7] = m_sts[7] ^ eic;
        e_msi  = m_men && nctl[5] && |(((nset & nctl) | (rise & m_sts)) & 16'h0019);
        e_intx = !m_men && nctl[5] && |(nctl & nsts & 16'h0019);
        @(posedge clk);
        @(negedge clk);
        chk("R2 slot_ctl", slot_ctl, nctl);
        chk("R5 slot_sts", slot_sts, nsts);
        chk("R8 intx_out", {15'd0, intx_out}, {15'd0, e_intx});
        chk("R9 msi_req", {15'd0, msi_req}, {15'd0, e_msi});
        chk("R7 hp_reject", {15'd0, hp_reject}, {15'd0, rej});
        m_ctl = nctl; m_sts = nsts; m_full = nfull;
    endtask

    task automatic idle();
        cycle(0, 0, 2'b00, 16'h0000, 0, 0, 0, 0);
    endtask

    task automatic wctl(input logic [1:0] be, input logic [15:0] wd);
        cycle(1, 0, be, wd, 0, 0, 0, 0);
    endtask

    task automatic wsts(input logic [15:0] wd);
        cycle(1, 1, 2'b11, wd, 0, 0, 0, 0);
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        m_ctl = 16'h03C0; m_sts = '0; m_full = 0; m_men = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 ctl reset", slot_ctl, 16'h03C0);
        chk("R1 sts reset", slot_sts, 16'h0000);
        chk("R1 irq reset", {13'd0, intx_out, msi_req, hp_reject}, 16'h0000);

        // R2 byte-enable merge and unimplemented bits
        wctl(2'b01, 16'hFFFF);
        chk("R2 low byte only", slot_ctl, 16'h03F9);
        wsts(16'h0019);
        // R4 identical rewrite is spurious
        wctl(2'b01, 16'hFFFF);
        chk("R4 no change no CC", slot_sts & 16'h0010, 16'h0000);
        wctl(2'b01, 16'h00C0);
        chk("R4 change sets CC", slot_sts & 16'h0010, 16'h0010);
        wsts(16'h0010);

        // R3 interlock toggle
        wctl(2'b10, 16'h0B00);
        chk("R3 EIC reads 0", slot_ctl & 16'h0800, 16'h0000);
        chk("R3 EIS set", slot_sts & 16'h0080, 16'h0080);
        // R7 refusal while locked
        cycle(0, 0, 2'b00, 16'h0, 0, 0, 1, 0);
        chk("R7 reject pulse", {15'd0, hp_reject}, 16'h0001);
        chk("R7 presence unchanged", slot_sts & 16'h0048, 16'h0000);
        idle();
        chk("R7 reject one cycle", {15'd0, hp_reject}, 16'h0000);
        wctl(2'b10, 16'h0B00);
        chk("R3 EIS released", slot_sts & 16'h0080, 16'h0000);
        wsts(16'h0019);

        // R6 occupancy transitions
        cycle(0, 0, 2'b00, 16'h0, 0, 0, 1, 0);
        chk("R6 insert", slot_sts & 16'h0048, 16'h0048);
        wsts(16'h0008);
        cycle(0, 0, 2'b00, 16'h0, 0, 0, 1, 0);
        chk("R6 insert when full ignored", slot_sts & 16'h0048, 16'h0040);
        cycle(0, 0, 2'b00, 16'h0, 0, 0, 0, 1);
        chk("R6 remove", slot_sts & 16'h0048, 16'h0008);

        // R8 level interrupt
        wsts(16'h0019);
        cycle(0, 0, 2'b00, 16'h0, 0, 0, 1, 0);
        wctl(2'b01, 16'h0028);
        chk("R8 intx on enable", {15'd0, intx_out}, 16'h0001);
        wsts(16'h0008);
        chk("R8 intx clears", {15'd0, intx_out}, 16'h0000);

        // R9 message on new event
        m_men = 1;
        wctl(2'b01, 16'h0021);
        wsts(16'h0019);
        cycle(0, 0, 2'b00, 16'h0, 1, 0, 0, 0);
        chk("R9 msi on event", {15'd0, msi_req}, 16'h0001);
        idle();
        chk("R9 msi one cycle", {15'd0, msi_req}, 16'h0000);
        cycle(0, 0, 2'b00, 16'h0, 1, 0, 0, 0);
        chk("R9 already set no msi", {15'd0, msi_req}, 16'h0000);
        chk("R11 no intx in msi mode", {15'd0, intx_out}, 16'h0000);

        // R10 message on enable rise
        wctl(2'b01, 16'h0020);
        chk("R10 disable no msi", {15'd0, msi_req}, 16'h0000);
        wctl(2'b01, 16'h0021);
        chk("R10 enable rise msi", {15'd0, msi_req}, 16'h0001);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit wr, sel, attn, cmdd, ins, rem;
            logic [1:0]  be;
            logic [15:0] wd;
            if (($urandom % 64) == 0) m_men = ~m_men;
            wr   = ($urandom % 4) == 0;
            sel  = $urandom % 2;
            be   = 2'($urandom);
            wd   = 16'($urandom);
            if (!sel && ($urandom % 3) != 0) wd[11] = 1'b0;
            attn = ($urandom % 8) == 0;
            cmdd = ($urandom % 16) == 0;
            ins  = ($urandom % 6) == 0;
            rem  = ($urandom % 6) == 0;
            cycle(wr, sel, be, wd, attn, cmdd, ins, rem);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule